// File: doc/BRIEF.md
# Dual-Channel Converter Power-Mode Sequencer

This block sits on the host side of a two-channel sampling converter. It drives the converter's active-low power-down line and its two-bit active-low sleep bus. It also raises a data-valid flag for each channel once that channel has been awake long enough for its samples to be trusted. The host states what it wants: a supply-stable indication, a power-down request and one active/sleep request bit per channel. The sequencer turns these requests into a legal sequence of pin states and counts the startup cycles.

Whenever the supply becomes stable, the converter must first be held in power-down for a programmable number of clock cycles, at least one. Only after that can any channel be woken. Waking from power-down takes a long startup count. Waking a channel from sleep takes a short one. A power-down request always wins over the sleep requests. Changes to the sleep requests that arrive while a startup count is running wait until the count has finished.

Top module: `adc_pwr_seq`

## Requirements
- R1: While `pd_n` is low, `slp_n` is 00 and both `valid` bits are 0. This is also the state after `rst`.
- R2: When `supply_ok` goes high, or is high when `rst` is released, `pd_n` stays low for exactly RST_CYC clock edges before any wake-up. When `supply_ok` is low at an edge, `pd_n` is low after that edge.
- R3: `slp_n[1]` controls channel 1 and `slp_n[0]` controls channel 0, with 1 meaning active. 00 is full-chip sleep, 01 enables channel 0 only, 10 enables channel 1 only and 11 enables both. The bus follows `req_act` with the same bit order.
- R4: When `pd_n` rises at edge E, each channel enabled on `slp_n` raises its `valid` flag at edge E+PD_WAKE and not earlier.
- R5: When a channel's `slp_n` bit rises at edge E and `pd_n` stays high, that channel's `valid` rises at edge E+SLP_WAKE. A channel that was already active keeps its `valid` high throughout.
- R6: A channel's `valid` falls on the same edge that its `slp_n` bit falls.
- R7: A change of `req_act` while a startup count is running leaves `slp_n` unchanged. The change is applied one edge after the count expires.
- R8: While running, `req_pd` high drives `pd_n` low on the next edge, even during a startup count. The following wake-up uses the full PD_WAKE count for every channel, including channels that were already valid before the power-down.
- R9: If `req_pd` is high when the reset hold ends, `pd_n` stays low until `req_pd` falls. `pd_n` then rises on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the converter clock, kept running in every mode |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | High when the converter supplies are stable |
| req_pd | input | 1 | Host request for full power-down |
| req_act | input | NCH | Per-channel request, 1 = active, 0 = sleep |
| pd_n | output | 1 | Active-low power-down line to the converter |
| slp_n | output | NCH | Active-low sleep bus; bit i enables channel i |
| valid | output | NCH | Per-channel data-valid flag |

## Verification
The bench builds the block with RST_CYC=2, PD_WAKE=30 and SLP_WAKE=5. These short counts let it watch every cycle of each startup window, not just its end points. With them it sweeps all sixteen transitions between sleep-bus settings and compares the outputs edge by edge against arithmetic expectations. They also make the slower scenarios affordable: a request queued mid-count, a power-down cutting a count short, and a power-down held through the end of the reset hold.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_RST = 2'd1,
    ST_PD  = 2'd2,
    ST_ON  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] lim,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= lim;
    end else if (abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < lim_q)); // R5
endmodule

// File: rtl/adc_seq_vflag.sv
module adc_seq_vflag (
  input  logic clk,
  input  logic rst,
  input  logic on_nxt,
  input  logic en_nxt,
  input  logic wake_nxt,
  output logic valid
);
  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= on_nxt & en_nxt & ~wake_nxt;
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int NCH      = 2,
  parameter int RST_CYC  = 1,
  parameter int PD_WAKE  = 900,
  parameter int SLP_WAKE = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           supply_ok,
  input  logic           req_pd,
  input  logic [NCH-1:0] req_act,
  output logic           pd_n,
  output logic [NCH-1:0] slp_n,
  output logic [NCH-1:0] valid
);
  import adc_seq_pkg::*;

  localparam int MAXW = (PD_WAKE > SLP_WAKE) ? PD_WAKE : SLP_WAKE;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int RW   = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LIM_PD  = CW'(PD_WAKE);
  localparam logic [CW-1:0] LIM_SLP = CW'(SLP_WAKE);
  localparam logic [RW-1:0] RST_END = RW'(RST_CYC - 1);

  seq_st_e        st_q, st_d;
  logic [RW-1:0]  rc_q, rc_d;
  logic [NCH-1:0] slp_q, slp_d;
  logic [NCH-1:0] wake_q, wake_d;
  logic           t_start, t_abort, t_busy, t_done;
  logic [CW-1:0]  t_lim;
  logic           on_d;

  always_comb begin
    st_d    = st_q;
    rc_d    = rc_q;
    slp_d   = slp_q;
    wake_d  = wake_q;
    t_start = 1'b0;
    t_abort = 1'b0;
    t_lim   = LIM_PD;
    unique case (st_q)
      ST_OFF: begin
        slp_d  = '0;
        wake_d = '0;
        if (supply_ok) begin
          st_d = ST_RST;
          rc_d = '0;
        end
      end
      ST_RST: begin
        if (!supply_ok) st_d = ST_OFF;
        else if (rc_q == RST_END) begin
          if (req_pd) st_d = ST_PD;
          else begin
            st_d    = ST_ON;
            slp_d   = req_act;
            wake_d  = req_act;
            t_start = 1'b1;
            t_lim   = LIM_PD;
          end
        end else rc_d = rc_q + 1'b1;
      end
      ST_PD: begin
        if (!supply_ok) st_d = ST_OFF;
        else if (!req_pd) begin
          st_d    = ST_ON;
          slp_d   = req_act;
          wake_d  = req_act;
          t_start = 1'b1;
          t_lim   = LIM_PD;
        end
      end
      default: begin
        if (!supply_ok || req_pd) begin
          st_d    = supply_ok ? ST_PD : ST_OFF;
          slp_d   = '0;
          wake_d  = '0;
          t_abort = 1'b1;
        end else if (t_busy) begin
          if (t_done) wake_d = '0;
        end else if (req_act != slp_q) begin
          slp_d  = req_act;
          wake_d = req_act & ~slp_q;
          if (|(req_act & ~slp_q)) begin
            t_start = 1'b1;
            t_lim   = LIM_SLP;
          end
        end
      end
    endcase
  end

  assign on_d = (st_d == ST_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_OFF;
      rc_q   <= '0;
      slp_q  <= '0;
      wake_q <= '0;
      pd_n   <= 1'b0;
    end else begin
      st_q   <= st_d;
      rc_q   <= rc_d;
      slp_q  <= slp_d;
      wake_q <= wake_d;
      pd_n   <= on_d;
    end
  end

  assign slp_n = slp_q;

  adc_seq_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (t_start),
    .abort (t_abort),
    .lim   (t_lim),
    .busy  (t_busy),
    .done  (t_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    adc_seq_vflag u_vf (
      .clk      (clk),
      .rst      (rst),
      .on_nxt   (on_d),
      .en_nxt   (slp_d[i]),
      .wake_nxt (wake_d[i]),
      .valid    (valid[i])
    );

    AST_RISE_AFTER_COUNT: assert property (@(posedge clk) disable iff (rst)
      $rose(valid[i]) |-> $past(t_busy)); // R5

    AST_FALL_WITH_SLEEP: assert property (@(posedge clk) disable iff (rst)
      $fell(slp_n[i]) |-> !valid[i]); // R6
  end

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pd_n |-> (valid == '0 && slp_n == '0)); // R1

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(supply_ok) |=> !pd_n); // R2

  AST_QUEUED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ON && t_busy && !t_done && supply_ok && !req_pd) |=> $stable(slp_n)); // R7

  AST_PD_PRIO: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ON && req_pd) |=> !pd_n); // R8
endmodule

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb;
  localparam int RC = 2;
  localparam int PW = 30;
  localparam int SW = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic       req_pd = 1'b0;
  logic [1:0] req_act = 2'b00;
  logic       pd_n;
  logic [1:0] slp_n;
  logic [1:0] valid;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  adc_pwr_seq #(.NCH(2), .RST_CYC(RC), .PD_WAKE(PW), .SLP_WAKE(SW)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .req_pd(req_pd),
    .req_act(req_act), .pd_n(pd_n), .slp_n(slp_n), .valid(valid)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string rq, input logic [4:0] exp);
    logic [4:0] act;
    act = {pd_n, slp_n, valid};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%b exp=%b (pd_n,slp_n,valid)", rq, $time, act, exp);
    end
  endtask

  task automatic summary();
    if (!fin) begin
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [1:0] exp_s, exp_v;
    // R1: reset state
    step(); step();
    chk("R1 reset", 5'b0_00_00);
    rst = 1'b0;
    step();
    chk("R2 supply low", 5'b0_00_00);

    // R2/R4: power-up with reset hold then long startup
    req_act   = 2'b11;
    supply_ok = 1'b1;
    for (int j = 1; j <= RC + PW + 2; j++) begin
      step();
      if (j <= RC)            chk("R2 hold", 5'b0_00_00);
      else if (j <= RC + PW)  chk("R4 pd startup", 5'b1_11_00);
      else                    chk("R4 pd valid", 5'b1_11_11);
    end

    // R3/R5/R6: sweep all sleep-bus transitions
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        req_act = 2'(f);
        for (int k = 0; k < SW + 4; k++) step();
        chk("R3 steady", {1'b1, 2'(f), 2'(f)});
        req_act = 2'(t);
        for (int j = 1; j <= SW + 3; j++) begin
          step();
          exp_s = 2'(t);
          for (int c = 0; c < 2; c++)
            exp_v[c] = exp_s[c] & ((f >> c) % 2 == 1 || j > SW);
          chk("R5 R6 sweep", {1'b1, exp_s, exp_v});
        end
      end
    end

    // R7: request queued during countdown
    req_act = 2'b01;
    for (int k = 0; k < SW + 4; k++) step();
    req_act = 2'b11;
    step();
    chk("R7 start", 5'b1_11_01);
    step();
    req_act = 2'b10;
    for (int j = 3; j <= SW + 2; j++) begin
      step();
      if (j <= SW)          chk("R7 held", 5'b1_11_01);
      else if (j == SW + 1) chk("R7 expire", 5'b1_11_11);
      else                  chk("R7 applied", 5'b1_10_10);
    end

    // R8: power-down cuts a countdown, restart uses full count
    req_act = 2'b01;
    for (int k = 0; k < SW + 4; k++) step();
    req_act = 2'b11;
    step(); step();
    req_pd = 1'b1;
    step();
    chk("R8 priority", 5'b0_00_00);
    step(); step();
    chk("R1 in pd", 5'b0_00_00);
    req_pd = 1'b0;
    for (int j = 1; j <= PW + 1; j++) begin
      step();
      if (j <= PW) chk("R8 restart", 5'b1_11_00);
      else         chk("R8 valid", 5'b1_11_11);
    end

    // R2: supply drop
    supply_ok = 1'b0;
    req_pd    = 1'b1;
    step();
    chk("R2 drop", 5'b0_00_00);

    // R9: power-down request held through reset hold
    supply_ok = 1'b1;
    req_act   = 2'b10;
    for (int j = 1; j <= RC + 4; j++) begin
      step();
      chk("R9 held", 5'b0_00_00);
    end
    req_pd = 1'b0;
    for (int j = 1; j <= PW + 1; j++) begin
      step();
      if (j <= PW) chk("R9 wake", 5'b1_10_00);
      else         chk("R9 valid", 5'b1_10_10);
    end

    summary();
  end
endmodule